// File: doc/BRIEF.md
# Nibble-Serial Register Access Decoder

This block sits behind a byte-wide host link and turns a stream of command bytes into accesses to a small register file. Every incoming byte is split into a 4-bit opcode (upper half) and a 4-bit payload (lower half). The host builds an 8-bit register address from two address commands, one per nibble. It builds each data byte from two data commands: the first only stores the low nibble, and the second supplies the high nibble and commits the byte.

After a committed write the address moves up by one. A host can therefore set the address once and then stream several data pairs into consecutive registers. A read command captures the register at the current address and offers it on a read-back output with a valid/ready handshake. The register file holds a fixed identification byte, a scratch byte for link testing, a mode byte that also drives an output of the block, and a few general-purpose bytes.

Top module: `nibcmd_regif`

## Requirements
- R1: A command with opcode 0x0 replaces address bits 3:0 with its payload and leaves address bits 7:4 unchanged.
- R2: A command with opcode 0x1 replaces address bits 7:4 with its payload and leaves address bits 3:0 unchanged.
- R3: A command with opcode 0x2 stores its payload as the pending low nibble. It changes no register and does not change the address. The pending nibble keeps its value until the next opcode 0x2 command, so several opcode 0x3 commands in a row reuse it.
- R4: A command with opcode 0x3 writes {payload, pending low nibble} to the register at the current address. The address then increments by one and wraps from 0xFF to 0x00.
- R5: After one address setup, a run of opcode 0x2/0x3 pairs writes consecutive registers.
- R6: A command with opcode 0x4 returns the register at the current address on rd_data, with rd_valid high, from the cycle after the command is accepted. The address does not change.
- R7: rd_valid and rd_data hold until rd_ready is high at a clock edge, and rd_valid then drops. While rd_valid is high, an opcode 0x4 command sees cmd_ready low. Commands with any other opcode are still accepted.
- R8: The register map is as follows. 0x00 reads the constant ID_VALUE (default 0x5C) and ignores writes. 0x01 is a read/write scratch byte. 0x02 is a read/write mode byte whose value is driven on mode_q. 0x03 to 0x06 are read/write general bytes. All other addresses read 0x00 and ignore writes.
- R9: Commands with opcodes 0x5 to 0xF are accepted and ignored: they change no register, no address and no pending nibble, and they start no read.
- R10: Reset clears the address to 0x00, the pending nibble to 0x0, and every writable register to 0x00. It also drops rd_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside |
| cmd_valid | input | 1 | Command byte present |
| cmd_ready | output | 1 | Command byte can be taken this cycle |
| cmd_byte | input | 8 | Opcode in bits 7:4, payload nibble in bits 3:0 |
| rd_valid | output | 1 | Read-back byte available |
| rd_ready | input | 1 | Consumer takes the read-back byte |
| rd_data | output | 8 | Read-back byte |
| mode_q | output | 8 | Current value of the mode register |

## Verification
The address and the pending nibble are internal state that cannot be seen directly. A fault in either shows up at the ports the next time a read or write uses it. A wrong address nibble makes the next read return a neighbouring or unmapped register one cycle after the read command. A stale or lost low nibble turns up as a wrong low half in the next read of the written register. A fault in the increment shows after a burst, when the registers read back shifted by one position. The bench sweeps every scratch value and every address so that each such fault reaches rd_data within a few commands.

// File: rtl/nibcmd_pkg.sv
package nibcmd_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;
  localparam int ADDR_W = 2 * NIB_W;

  typedef enum logic [NIB_W-1:0] {
    OP_ADDR_LO = 4'h0,
    OP_ADDR_HI = 4'h1,
    OP_DATA_LO = 4'h2,
    OP_DATA_HI = 4'h3,
    OP_READ    = 4'h4
  } op_e;

  localparam logic [ADDR_W-1:0] ADR_ID      = 8'h00;
  localparam logic [ADDR_W-1:0] ADR_SCRATCH = 8'h01;
  localparam logic [ADDR_W-1:0] ADR_MODE    = 8'h02;
  localparam logic [ADDR_W-1:0] ADR_GP_BASE = 8'h03;
endpackage

// File: rtl/nibcmd_parser.sv
module nibcmd_parser
  import nibcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [BYTE_W-1:0] cmd_byte,
  output logic [ADDR_W-1:0] addr_q,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_req
);
  logic [NIB_W-1:0]  op;
  logic [NIB_W-1:0]  nib;
  logic [NIB_W-1:0]  lo_q;
  logic [NIB_W-1:0]  lo_d;
  logic [ADDR_W-1:0] addr_d;
  logic              addr_en;
  logic              lo_en;

  assign op  = cmd_byte[BYTE_W-1:NIB_W];
  assign nib = cmd_byte[NIB_W-1:0];

  // Next-state decode of one accepted command
  always_comb begin
    addr_d  = addr_q;
    lo_d    = lo_q;
    addr_en = 1'b0;
    lo_en   = 1'b0;
    wr_en   = 1'b0;
    rd_req  = 1'b0;
    if (fire) begin
      case (op)
        OP_ADDR_LO: begin
          addr_d[NIB_W-1:0] = nib;
          addr_en           = 1'b1;
        end
        OP_ADDR_HI: begin
          addr_d[ADDR_W-1:NIB_W] = nib;
          addr_en                = 1'b1;
        end
        OP_DATA_LO: begin
          lo_d  = nib;
          lo_en = 1'b1;
        end
        OP_DATA_HI: begin
          wr_en   = 1'b1;
          addr_d  = addr_q + {{(ADDR_W-1){1'b0}}, 1'b1};
          addr_en = 1'b1;
        end
        OP_READ: begin
          rd_req = 1'b1;
        end
        default: begin
          addr_en = 1'b0;
        end
      endcase
    end
  end

  assign wr_data = {nib, lo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      lo_q   <= '0;
    end else begin
      if (addr_en) addr_q <= addr_d;
      if (lo_en)   lo_q   <= lo_d;
    end
  end
endmodule

// File: rtl/nibcmd_regfile.sv
module nibcmd_regfile
  import nibcmd_pkg::*;
#(
  parameter logic [7:0] ID_VALUE = 8'h5C,
  parameter int         NUM_GP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] mode_q
);
  logic [BYTE_W-1:0] scratch_q;
  logic [BYTE_W-1:0] gp_q [NUM_GP];
  logic [NUM_GP-1:0] gp_en;
  logic              scratch_en;
  logic              mode_en;

  assign scratch_en = wr_en && (wr_addr == ADR_SCRATCH);
  assign mode_en    = wr_en && (wr_addr == ADR_MODE);

  for (genvar g = 0; g < NUM_GP; g++) begin : g_slot
    localparam logic [ADDR_W-1:0] SLOT = ADR_GP_BASE + ADDR_W'(g);
    assign gp_en[g] = wr_en && (wr_addr == SLOT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scratch_q <= '0;
      mode_q    <= '0;
    end else begin
      if (scratch_en) scratch_q <= wr_data;
      if (mode_en)    mode_q    <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_GP; i++) gp_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_GP; i++) begin
        if (gp_en[i]) gp_q[i] <= wr_data;
      end
    end
  end

  // Read multiplexer; unmapped addresses return zero
  always_comb begin
    rd_data = '0;
    if (rd_addr == ADR_ID)      rd_data = ID_VALUE;
    if (rd_addr == ADR_SCRATCH) rd_data = scratch_q;
    if (rd_addr == ADR_MODE)    rd_data = mode_q;
    for (int i = 0; i < NUM_GP; i++) begin
      if (rd_addr == ADR_GP_BASE + ADDR_W'(i)) rd_data = gp_q[i];
    end
  end
endmodule

// File: rtl/nibcmd_rdport.sv
module nibcmd_rdport
  import nibcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [BYTE_W-1:0] rd_word,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [BYTE_W-1:0] rd_data
);
  logic valid_d;
  logic data_en;

  always_comb begin
    data_en = rd_req;
    if (rd_req)                     valid_d = 1'b1;
    else if (rd_valid && !rd_ready) valid_d = 1'b1;
    else                            valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= valid_d;
      if (data_en) rd_data <= rd_word;
    end
  end
endmodule

// File: rtl/nibcmd_regif.sv
module nibcmd_regif
  import nibcmd_pkg::*;
#(
  parameter logic [7:0] ID_VALUE = 8'h5C,
  parameter int         NUM_GP   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [7:0] cmd_byte,
  output logic       rd_valid,
  input  logic       rd_ready,
  output logic [7:0] rd_data,
  output logic [7:0] mode_q
);
  logic              fire;
  logic [ADDR_W-1:0] cur_addr;
  logic              wr_en;
  logic [BYTE_W-1:0] wr_data;
  logic              rd_req;
  logic [BYTE_W-1:0] rd_word;

  // A read waits while the previous result is still unconsumed
  assign cmd_ready = !((cmd_byte[BYTE_W-1:NIB_W] == OP_READ) && rd_valid);
  assign fire      = cmd_valid && cmd_ready;

  nibcmd_parser u_parse (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .cmd_byte (cmd_byte),
    .addr_q   (cur_addr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_req   (rd_req)
  );

  nibcmd_regfile #(
    .ID_VALUE (ID_VALUE),
    .NUM_GP   (NUM_GP)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (cur_addr),
    .wr_data (wr_data),
    .rd_addr (cur_addr),
    .rd_data (rd_word),
    .mode_q  (mode_q)
  );

  nibcmd_rdport u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .rd_word  (rd_word),
    .rd_ready (rd_ready),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/nibcmd_regif_chk.sv
module nibcmd_regif_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [7:0] cmd_byte,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic [7:0] mode_q,
  input logic [7:0] cur_addr
);
  logic       fire;
  logic [3:0] op;

  assign fire = cmd_valid && cmd_ready;
  assign op   = cmd_byte[7:4];

  AST_ADDR_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    fire && op == 4'h0 |=> cur_addr[3:0] == $past(cmd_byte[3:0]) && cur_addr[7:4] == $past(cur_addr[7:4])); // R1
  AST_ADDR_HI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    fire && op == 4'h1 |=> cur_addr[7:4] == $past(cmd_byte[3:0]) && cur_addr[3:0] == $past(cur_addr[3:0])); // R2
  AST_DATA_LO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    fire && op == 4'h2 |=> $stable(cur_addr) && $stable(mode_q)); // R3
  AST_COMMIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fire && op == 4'h3 |=> cur_addr == $past(cur_addr) + 8'd1); // R4
  AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    fire && op == 4'h4 |=> rd_valid && $stable(cur_addr)); // R6
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data)); // R7
  AST_READ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && op == 4'h4 && rd_valid |-> !cmd_ready); // R7
  AST_BAD_OP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    fire && op > 4'h4 && !rd_valid |=> $stable(cur_addr) && $stable(mode_q) && !rd_valid); // R9
endmodule

bind nibcmd_regif nibcmd_regif_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_byte  (cmd_byte),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_data   (rd_data),
  .mode_q    (mode_q),
  .cur_addr  (cur_addr)
);

// File: tb/tb_nibcmd_regif.sv
module tb_nibcmd_regif;
  localparam logic [7:0] ID_V = 8'h5C;

  logic       clk;
  logic       rst_n;
  logic       cmd_valid;
  logic       cmd_ready;
  logic [7:0] cmd_byte;
  logic       rd_valid;
  logic       rd_ready;
  logic [7:0] rd_data;
  logic [7:0] mode_q;

  int total;
  int fails;

  // Bench-side model built from the requirements
  logic [7:0] m_addr;
  logic [3:0] m_lo;
  logic [7:0] m_scr;
  logic [7:0] m_mode;
  logic [7:0] m_gp [4];

  nibcmd_regif dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_byte  (cmd_byte),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_data   (rd_data),
    .mode_q    (mode_q)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    if (a == 8'h00) return ID_V;
    if (a == 8'h01) return m_scr;
    if (a == 8'h02) return m_mode;
    if (a >= 8'h03 && a <= 8'h06) return m_gp[a - 8'h03];
    return 8'h00;
  endfunction

  task automatic model_reset();
    m_addr = 8'h00;
    m_lo   = 4'h0;
    m_scr  = 8'h00;
    m_mode = 8'h00;
    for (int i = 0; i < 4; i++) m_gp[i] = 8'h00;
  endtask

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'h01) m_scr = d;
    if (a == 8'h02) m_mode = d;
    if (a >= 8'h03 && a <= 8'h06) m_gp[a - 8'h03] = d;
  endtask

  // Called at a negedge; returns at the negedge after acceptance
  task automatic send(input logic [7:0] b);
    cmd_valid = 1'b1;
    cmd_byte  = b;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] b);
    send(b);
    case (b[7:4])
      4'h0: m_addr[3:0] = b[3:0];
      4'h1: m_addr[7:4] = b[3:0];
      4'h2: m_lo = b[3:0];
      4'h3: begin
        model_write(m_addr, {b[3:0], m_lo});
        m_addr = m_addr + 8'd1;
      end
      default: ;
    endcase
  endtask

  task automatic set_addr(input logic [7:0] a);
    cmd({4'h0, a[3:0]});
    cmd({4'h1, a[7:4]});
  endtask

  task automatic wr_pair(input logic [7:0] d);
    cmd({4'h2, d[3:0]});
    cmd({4'h3, d[7:4]});
  endtask

  task automatic rd_check(input string tag);
    send(8'h40);
    chk({tag, " rd_valid"}, {7'd0, rd_valid}, 8'h01);
    chk({tag, " rd_data"}, rd_data, exp_rd(m_addr));
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog (all requirements) act=running exp=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] held;
    total     = 0;
    fails     = 0;
    rst_n     = 1'b0;
    cmd_valid = 1'b0;
    cmd_byte  = 8'h00;
    rd_ready  = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state at the ports, address starts at ID register
    chk("R10 rd_valid", {7'd0, rd_valid}, 8'h00);
    chk("R10 mode_q", mode_q, 8'h00);
    chk("R10 cmd_ready", {7'd0, cmd_ready}, 8'h01);
    rd_check("R10 addr zero / R8 id");
    set_addr(8'h01);
    rd_check("R10 scratch cleared");

    // R4 R8: every scratch value written and read back
    for (int v = 0; v < 256; v++) begin
      set_addr(8'h01);
      wr_pair(v[7:0]);
      set_addr(8'h01);
      rd_check("R4 scratch sweep");
    end

    // R8: mode register drives mode_q
    set_addr(8'h02);
    wr_pair(8'hA5);
    chk("R8 mode_q", mode_q, 8'hA5);

    // R5: burst from 0x01 across six consecutive registers
    set_addr(8'h01);
    wr_pair(8'h11);
    wr_pair(8'h22);
    wr_pair(8'h33);
    wr_pair(8'h44);
    wr_pair(8'h55);
    wr_pair(8'h66);
    chk("R5 mode_q in burst", mode_q, 8'h22);
    rd_check("R4 increment after burst");
    for (int a = 1; a <= 6; a++) begin
      set_addr(a[7:0]);
      rd_check("R5 burst readback");
    end

    // R3: data-low alone writes nothing and keeps the address
    set_addr(8'h01);
    cmd(8'h27);
    rd_check("R3 no write on data-low");
    cmd(8'h39);
    rd_check("R3 pending nibble reused");
    cmd(8'h3B);
    set_addr(8'h01);
    rd_check("R4 committed byte");
    set_addr(8'h02);
    rd_check("R3 second commit keeps low nibble");
    chk("R3 mode_q", mode_q, 8'hB7);

    // R1 R2: nibble-wise address updates
    set_addr(8'h03);
    cmd(8'h04);
    rd_check("R1 low nibble only");
    cmd(8'h1F);
    rd_check("R2 high nibble only");
    cmd(8'h10);
    rd_check("R2 back to low page");

    // R9: undefined opcodes are ignored
    set_addr(8'h02);
    cmd(8'h2E);
    for (int o = 5; o < 16; o++) begin
      for (int p = 0; p < 16; p += 5) begin
        cmd({o[3:0], p[3:0]});
        chk("R9 no read started", {7'd0, rd_valid}, 8'h00);
      end
    end
    rd_check("R9 address and register unchanged");
    chk("R9 mode_q", mode_q, 8'hB7);
    cmd(8'h31);
    set_addr(8'h02);
    rd_check("R9 pending nibble unchanged");

    // R8: ID is read-only, unmapped writes dropped
    set_addr(8'h00);
    wr_pair(8'h33);
    set_addr(8'h00);
    rd_check("R8 id write ignored");
    set_addr(8'h40);
    wr_pair(8'h99);
    set_addr(8'h40);
    rd_check("R8 unmapped reads zero");

    // R4: wrap from 0xFF to 0x00
    set_addr(8'hFF);
    wr_pair(8'h77);
    rd_check("R4 wrap to zero");

    // R8: full address sweep
    for (int a = 0; a < 256; a++) begin
      set_addr(a[7:0]);
      rd_check("R8 map sweep");
    end

    // R7: hold while not consumed, read blocked, others accepted
    set_addr(8'h01);
    send(8'h40);
    held = rd_data;
    chk("R6 read data", held, exp_rd(8'h01));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R7 valid held", {7'd0, rd_valid}, 8'h01);
      chk("R7 data held", rd_data, held);
    end
    cmd_valid = 1'b1;
    cmd_byte  = 8'h40;
    #1;
    chk("R7 read blocked", {7'd0, cmd_ready}, 8'h00);
    cmd_byte = 8'h03;
    #1;
    chk("R7 other opcode ready", {7'd0, cmd_ready}, 8'h01);
    cmd_valid = 1'b0;
    cmd(8'h03);
    chk("R7 data held after other cmd", rd_data, held);
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
    chk("R7 valid drops", {7'd0, rd_valid}, 8'h00);
    rd_check("R7 new address after pending read");

    // R10: reset mid-run clears state
    set_addr(8'h05);
    cmd(8'h2D);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
    chk("R10 mode_q after reset", mode_q, 8'h00);
    rd_check("R10 address cleared");
    set_addr(8'h01);
    cmd(8'h3C);
    set_addr(8'h01);
    rd_check("R10 pending nibble cleared");
    set_addr(8'h05);
    rd_check("R10 general cleared");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule